// File: doc/BRIEF.md
# Four-by-Four Stable Matching Engine

This engine pairs four proposers with four acceptors so that no proposer and acceptor would both rather be with each other than with the partners they were given. It uses the proposer-driven deferred-acceptance procedure. On a start strobe it captures one preference byte for every person on both sides. It then runs one proposal round per clock until no proposer is left unpaired. When it finishes, it publishes the four pairs as a packed 16-bit word and raises a one-cycle completion pulse.

Each preference byte holds four 2-bit person ids. The first choice sits in the top two bits. In a round, every unpaired proposer asks her best acceptor not yet tried. Each acceptor weighs his current partner, if he has one, against all new askers and keeps only the one he ranks best. The others, including a partner he drops, become free for the next round.

Top module: `smx_engine`

## Requirements
- R1: While reset is high and after it is released, busy_o and done_o are low and pairs_o is 0x0000.
- R2: A start_i high at a clock edge while idle captures both preference words, and busy_o is high from the next cycle. Proposer k's byte is prop_prefs_i[31-8k -: 8] and acceptor k's byte is acc_prefs_i[31-8k -: 8].
- R3: Within a byte, bits [7:6] name the first choice and bits [1:0] the last. Each free proposer proposes to her best acceptor she has not tried, moving one place down her list after every rejection or drop.
- R4: An acceptor keeps the best-ranked person among his current partner and all of this round's proposers. A newcomer replaces the current partner only if she is strictly better. Among equally ranked newcomers, the lower proposer id wins. A replaced partner is free in the next round.
- R5: A proposer id that does not appear in an acceptor's byte ranks below every id that does appear.
- R6: Each round takes one clock. For a run of k rounds, done_o is high k+1 cycles after the start edge, and busy_o is low in that cycle.
- R7: done_o is high for exactly one cycle. pairs_o changes only in that cycle and holds its value through any later run until that run completes.
- R8: pairs_o holds four nibbles {proposer id, acceptor id}, with proposer 0 in bits [15:12] and proposer 3 in bits [3:0]. The four acceptor ids are all distinct.
- R9: A start_i received while busy_o is high has no effect on the running computation or on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch strobe, honoured only while idle |
| prop_prefs_i | input | 32 | Four proposer preference bytes, proposer 0 in the top byte |
| acc_prefs_i | input | 32 | Four acceptor preference bytes, acceptor 0 in the top byte |
| busy_o | output | 1 | High while proposal rounds run |
| done_o | output | 1 | One-cycle completion pulse |
| pairs_o | output | 16 | Packed final pairs |

## Verification
Two acceptor functions can land in the same round: choosing among several simultaneous proposals, and trading up from an existing partner. One scenario is built so that an engaged acceptor receives two new proposals in the same round and ranks one of them above his partner and above the other newcomer. The bench then checks that both the dropped partner and the losing newcomer go on to their next choices. A second scenario places two proposers that the acceptor does not list against each other, and later against his unlisted partner. In each case the completion cycle and the final pair word are compared with values worked out by hand.

// File: rtl/smx_pkg.sv
package smx_pkg;

    localparam int NUM    = 4;
    localparam int ID_W   = $clog2(NUM);
    localparam int PREF_W = NUM * ID_W;
    localparam int RANK_W = ID_W + 1;
    localparam int PAIR_W = 2 * ID_W;
    localparam int WORD_W = NUM * PREF_W;
    localparam int OUT_W  = NUM * PAIR_W;

    typedef logic [ID_W-1:0]   id_t;
    typedef logic [RANK_W-1:0] rank_t;

    // index 0 is the most preferred entry
    typedef id_t [NUM-1:0] plist_t;

    typedef struct packed {
        logic valid;
        id_t  who;
    } hold_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    localparam rank_t RANK_NONE = '1;

    // byte layout: first choice in the top bits
    function automatic plist_t unpack_pref(input logic [PREF_W-1:0] b);
        plist_t l;
        for (int i = 0; i < NUM; i++) begin
            l[i] = b[PREF_W-1-i*ID_W -: ID_W];
        end
        return l;
    endfunction

    // position of the first match; unlisted ids rank as NUM
    function automatic rank_t rank_of(input plist_t l, input id_t who);
        rank_t r;
        r = rank_t'(NUM);
        for (int i = NUM - 1; i >= 0; i--) begin
            if (l[i] == who) r = rank_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/smx_proposer_bank.sv
module smx_proposer_bank
    import smx_pkg::*;
(
    input  plist_t [NUM-1:0] lists_i,
    input  id_t    [NUM-1:0] ptr_i,
    input  logic   [NUM-1:0] engaged_i,
    output logic   [NUM-1:0] req_o,
    output id_t    [NUM-1:0] target_o
);

    for (genvar p = 0; p < NUM; p++) begin : g_prop
        always_comb begin
            req_o[p]    = ~engaged_i[p];
            target_o[p] = lists_i[p][ptr_i[p]];
        end
    end

endmodule

// File: rtl/smx_acceptor_cell.sv
module smx_acceptor_cell
    import smx_pkg::*;
#(
    parameter int ACC_ID = 0
) (
    input  plist_t           list_i,
    input  hold_t            hold_i,
    input  logic   [NUM-1:0] req_i,
    input  id_t    [NUM-1:0] target_i,
    output hold_t            hold_o
);

    localparam id_t MY_ID = id_t'(ACC_ID);

    rank_t best_rank;

    always_comb begin
        hold_o    = hold_i;
        best_rank = hold_i.valid ? rank_of(list_i, hold_i.who) : RANK_NONE;
        // ascending scan with strict compare: incumbent and lower id win ties
        for (int p = 0; p < NUM; p++) begin
            if (req_i[p] && (target_i[p] == MY_ID)
                && (rank_of(list_i, id_t'(p)) < best_rank)) begin
                best_rank    = rank_of(list_i, id_t'(p));
                hold_o.valid = 1'b1;
                hold_o.who   = id_t'(p);
            end
        end
    end

endmodule

// File: rtl/smx_pair_pack.sv
module smx_pair_pack
    import smx_pkg::*;
(
    input  hold_t [NUM-1:0]   hold_i,
    output logic  [NUM-1:0]   engaged_o,
    output logic  [OUT_W-1:0] word_o
);

    id_t [NUM-1:0] partner;

    always_comb begin
        engaged_o = '0;
        partner   = '0;
        for (int a = 0; a < NUM; a++) begin
            if (hold_i[a].valid) begin
                engaged_o[hold_i[a].who] = 1'b1;
                partner[hold_i[a].who]   = id_t'(a);
            end
        end
        for (int p = 0; p < NUM; p++) begin
            word_o[(NUM-1-p)*PAIR_W +: PAIR_W] = {id_t'(p), partner[p]};
        end
    end

endmodule

// File: rtl/smx_engine.sv
module smx_engine
    import smx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] prop_prefs_i,
    input  logic [WORD_W-1:0] acc_prefs_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [OUT_W-1:0]  pairs_o
);

    st_e                 state_q;
    plist_t [NUM-1:0]    plist_q;
    plist_t [NUM-1:0]    alist_q;
    id_t    [NUM-1:0]    ptr_q;
    hold_t  [NUM-1:0]    hold_q;
    hold_t  [NUM-1:0]    hold_nxt;
    logic                done_q;
    logic   [OUT_W-1:0]  pairs_q;

    logic   [NUM-1:0]    engaged;
    logic   [NUM-1:0]    eng_nxt;
    logic   [NUM-1:0]    req;
    id_t    [NUM-1:0]    target;
    logic   [OUT_W-1:0]  packed_now;

    smx_proposer_bank u_props (
        .lists_i   (plist_q),
        .ptr_i     (ptr_q),
        .engaged_i (engaged),
        .req_o     (req),
        .target_o  (target)
    );

    for (genvar a = 0; a < NUM; a++) begin : g_acc
        smx_acceptor_cell #(.ACC_ID(a)) u_cell (
            .list_i   (alist_q[a]),
            .hold_i   (hold_q[a]),
            .req_i    (req),
            .target_i (target),
            .hold_o   (hold_nxt[a])
        );
    end

    smx_pair_pack u_pack (
        .hold_i    (hold_q),
        .engaged_o (engaged),
        .word_o    (packed_now)
    );

    always_comb begin
        eng_nxt = '0;
        for (int a = 0; a < NUM; a++) begin
            if (hold_nxt[a].valid) eng_nxt[hold_nxt[a].who] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            plist_q <= '0;
            alist_q <= '0;
            ptr_q   <= '0;
            hold_q  <= '0;
            done_q  <= 1'b0;
            pairs_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        for (int k = 0; k < NUM; k++) begin
                            plist_q[k] <= unpack_pref(prop_prefs_i[(NUM-1-k)*PREF_W +: PREF_W]);
                            alist_q[k] <= unpack_pref(acc_prefs_i[(NUM-1-k)*PREF_W +: PREF_W]);
                        end
                        ptr_q   <= '0;
                        hold_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (&engaged) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        pairs_q <= packed_now;
                    end else begin
                        hold_q <= hold_nxt;
                        // anyone left free after the round was refused or dropped
                        for (int p = 0; p < NUM; p++) begin
                            if (!eng_nxt[p]) ptr_q[p] <= ptr_q[p] + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state_q == ST_RUN);
    assign done_o  = done_q;
    assign pairs_o = pairs_q;

endmodule

// File: rtl/smx_engine_chk.sv
module smx_engine_chk
    import smx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OUT_W-1:0] pairs_o
);

    logic [NUM-1:0] acc_seen;
    logic           prop_fields_ok;

    always_comb begin
        acc_seen       = '0;
        prop_fields_ok = 1'b1;
        for (int p = 0; p < NUM; p++) begin
            acc_seen[pairs_o[(NUM-1-p)*PAIR_W +: ID_W]] = 1'b1;
            if (pairs_o[(NUM-1-p)*PAIR_W + ID_W +: ID_W] != id_t'(p)) prop_fields_ok = 1'b0;
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(pairs_o));

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    p_done_after_run_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_run_kept_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    p_one_to_one_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones(acc_seen) == NUM && prop_fields_ok));

endmodule

bind smx_engine smx_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .pairs_o (pairs_o)
);

// File: tb/smx_engine_test.sv
module smx_engine_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] prop_prefs_i;
    logic [31:0] acc_prefs_i;
    logic        busy_o;
    logic        done_o;
    logic [15:0] pairs_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] prev_pairs = 16'h0000;

    always #10 clk = ~clk;

    smx_engine uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .prop_prefs_i (prop_prefs_i),
        .acc_prefs_i  (acc_prefs_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .pairs_o      (pairs_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one launch: checks start response, completion cycle, result and hold
    task automatic run_case(input string name, input logic [31:0] pp,
                            input logic [31:0] ap, input logic [15:0] exp_pairs,
                            input int exp_rounds, input bit poke);
        int seen;
        @(negedge clk);
        start_i = 1'b1; prop_prefs_i = pp; acc_prefs_i = ap;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2", {name, " busy after start"}, 32'(busy_o), 32'd1);
        chk(done_o == 1'b0, "R7", {name, " no done at launch"}, 32'(done_o), 32'd0);
        chk(pairs_o == prev_pairs, "R7", {name, " old result kept"}, 32'(pairs_o), 32'(prev_pairs));
        if (poke) begin
            // R9: second strobe while busy with different preferences
            start_i = 1'b1; prop_prefs_i = ~pp; acc_prefs_i = ~ap;
        end
        seen = 0;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin
                seen = c;
                break;
            end
        end
        chk(seen == exp_rounds + 1, poke ? "R9" : "R6", {name, " completion cycle"},
            32'(seen), 32'(exp_rounds + 1));
        chk(pairs_o == exp_pairs, poke ? "R9" : "R8", {name, " pair word"},
            32'(pairs_o), 32'(exp_pairs));
        chk(busy_o == 1'b0, "R6", {name, " idle at done"}, 32'(busy_o), 32'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", {name, " done one cycle"}, 32'(done_o), 32'd0);
        repeat (3) @(negedge clk);
        chk(pairs_o == exp_pairs, "R7", {name, " result held"}, 32'(pairs_o), 32'(exp_pairs));
        prev_pairs = exp_pairs;
    endtask

    task automatic test_reset();
        rst = 1'b1; start_i = 1'b0; prop_prefs_i = '0; acc_prefs_i = '0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy in reset", 32'(busy_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0, "R1", "done after reset", 32'(done_o), 32'd0);
        chk(pairs_o == 16'h0, "R1", "pairs after reset", 32'(pairs_o), 32'd0);
        chk(busy_o == 1'b0, "R1", "idle after reset", 32'(busy_o), 32'd0);
    endtask

    // R3/R4: two refused, one trade-up, three rounds
    task automatic test_mixed();
        run_case("mixed", 32'h4E784EE4, 32'hE486E178, 16'h079E, 3, 1'b0);
    endtask

    // R4: engaged acceptor 0 gets two proposals at once, keeps the best
    task automatic test_multi_tradeup();
        run_case("multi_tradeup", 32'h1B4B4B4B, 32'hE16C1B1B, 16'h25BC, 5, 1'b0);
    endtask

    // R3/R9: identical lists cascade over four rounds, with a stray start
    task automatic test_same_lists_poke();
        run_case("same_lists", 32'h1B1B1B1B, 32'h1B1B1B1B, 16'h05AF, 4, 1'b1);
    endtask

    // R3: distinct first choices settle in a single round
    task automatic test_one_round();
        run_case("one_round", 32'h1B4B87C6, 32'h1B1B1B1B, 16'h05AF, 1, 1'b0);
    endtask

    // R5/R4: unlisted proposers tie, lower id wins, incumbent kept
    task automatic test_unlisted();
        run_case("unlisted", 32'hC61B1B4B, 32'h001B1B1B, 16'h349E, 4, 1'b0);
    endtask

    initial begin
        test_reset();
        test_mixed();
        test_multi_tradeup();
        test_same_lists_poke();
        test_one_round();
        test_unlisted();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule